// File: doc/BRIEF.md
# Memory dependence scoreboard

This block sits beside the issue queue of an out-of-order core. It keeps a small table of the loads, stores and barriers that are in flight, keyed by sequence number. It decides when each memory operation may be handed to the issue queue. An operation is released when its source registers are ready and no older store or barrier still holds it back. Ordinary operations are released when both conditions hold. Non-speculative operations and barriers are released only on an explicit command.

On insert the caller supplies the operation kind, sequence number, thread, a predicted producer sequence number and whether its registers are already ready. A memory barrier that is still outstanding replaces the prediction for the kinds it gates. Later commands name an entry by sequence number. These commands are: register-ready, non-speculative go, completion, and squash by thread and sequence number. Completion of a store or barrier wakes every entry linked to it. The block emits at most one ready pulse per cycle, carrying the sequence number and thread of the released operation.

Top module: `mdu_scoreboard`

## Requirements
- R1: An insert whose producer sequence number is zero, or matches no live entry, is memory-ready at once. With registers ready it pulses `rdy_valid_o` in the cycle after the insert edge.
- R2: An entry whose registers were not ready pulses only in the cycle after a register-ready command names it, and only once memory-ready.
- R3: An entry linked to a live store waits for that store's completion. At completion it pulses in the next cycle if its registers are ready. If they are not, it only becomes memory-ready and pulses after its register-ready command.
- R4: `ins_kind_i` is encoded as 0 load, 1 store, 2 full barrier, 3 write barrier. A full barrier makes later loads and stores depend on it, and a write barrier does this for stores only. Either one overrides `ins_pred_i`.
- R5: A completion clears a barrier gate only when its sequence number equals the one recorded for that gate. A younger barrier keeps the gate closed after an older one completes.
- R6: Barriers and entries inserted with `ins_nonspec_i` high pulse only in the cycle after a go command names them.
- R7: A squash removes the entries of `squash_tid_i` whose sequence number is greater than `squash_seq_i`. Removed entries never pulse, and other threads are untouched.
- R8: At most one pulse per cycle, and each entry pulses at most once. Among candidates the lowest sequence number goes first, and the rest follow in later cycles.
- R9: `full_o` is high when all entries are occupied, and an insert is then dropped. An entry named by a completion still counts as occupied in the next cycle and is free one cycle later. After reset the table is empty and nothing pulses.
- R10: Only stores and barriers act as producers. A prediction that names a load, or a producer completing in the same cycle as the insert, gives no dependence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_kind_i | input | 2 | Operation kind (R4 encoding) |
| ins_nonspec_i | input | 1 | Operation waits for a go command |
| ins_seq_i | input | SEQ_W | Sequence number of the new operation |
| ins_tid_i | input | TID_W | Thread of the new operation |
| ins_pred_i | input | SEQ_W | Predicted producer sequence number, 0 for none |
| ins_regs_rdy_i | input | 1 | Source registers already ready |
| full_o | output | 1 | No free entry |
| regrdy_valid_i | input | 1 | Register-ready command |
| regrdy_seq_i | input | SEQ_W | Entry named by the register-ready command |
| go_valid_i | input | 1 | Non-speculative go command |
| go_seq_i | input | SEQ_W | Entry named by the go command |
| done_valid_i | input | 1 | Completion command |
| done_seq_i | input | SEQ_W | Completing entry |
| squash_valid_i | input | 1 | Squash command |
| squash_seq_i | input | SEQ_W | Squash point; younger entries are removed |
| squash_tid_i | input | TID_W | Thread being squashed |
| rdy_valid_o | output | 1 | Ready pulse |
| rdy_seq_o | output | SEQ_W | Sequence number of the released entry |
| rdy_tid_o | output | TID_W | Thread of the released entry |

## Verification
Release timing is tried with several input patterns:
- Independent inserts, both with and without ready registers. These separate the immediate path from the register-ready path.
- A load that names another load. This shows that loads are not treated as producers.
- Chains on a store where the dependent's registers are ready at completion in one case and not in the other. These show the difference between waking to ready and waking to memory-ready.
- A full barrier and a write barrier in turn. These show which kinds each gate holds.
- Two write barriers back to back. This shows that an older completion does not open a younger gate.
- A two-thread squash, two dependents released by one completion, and filling the table. These show thread isolation, oldest-first ordering, and the one-cycle delay before a slot is freed.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    MK_LOAD    = 2'd0,
    MK_STORE   = 2'd1,
    MK_FULLBAR = 2'd2,
    MK_WRBAR   = 2'd3
  } mem_kind_e;
endpackage

// File: rtl/mdu_entry.sv
module mdu_entry
  import mdu_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int TID_W = 1,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  mem_kind_e        a_kind_i,
  input  logic             a_nonspec_i,
  input  logic [SEQ_W-1:0] a_seq_i,
  input  logic [TID_W-1:0] a_tid_i,
  input  logic             a_regs_i,
  input  logic             a_dep_v_i,
  input  logic [IDX_W-1:0] a_dep_idx_i,
  input  logic             regrdy_v_i,
  input  logic [SEQ_W-1:0] regrdy_seq_i,
  input  logic             go_v_i,
  input  logic [SEQ_W-1:0] go_seq_i,
  input  logic             done_v_i,
  input  logic [SEQ_W-1:0] done_seq_i,
  input  logic             sq_v_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  input  logic [TID_W-1:0] sq_tid_i,
  input  logic             wake_v_i,
  input  logic [IDX_W-1:0] wake_idx_i,
  input  logic             sent_i,
  output logic             valid_o,
  output logic             live_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [TID_W-1:0] tid_o,
  output logic             prod_o,
  output logic             done_hit_o,
  output logic             cand_o
);
  logic             valid_q, dying_q, nonspec_q, regs_q, mem_q, dep_v_q, go_q, sent_q;
  mem_kind_e        kind_q;
  logic [SEQ_W-1:0] seq_q;
  logic [TID_W-1:0] tid_q;
  logic [IDX_W-1:0] dep_idx_q;

  logic live, kill, is_bar;
  assign live   = valid_q && !dying_q;
  assign kill   = sq_v_i && (tid_q == sq_tid_i) && (seq_q > sq_seq_i);
  assign is_bar = (kind_q == MK_FULLBAR) || (kind_q == MK_WRBAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      dying_q   <= 1'b0;
      nonspec_q <= 1'b0;
      regs_q    <= 1'b0;
      mem_q     <= 1'b0;
      dep_v_q   <= 1'b0;
      go_q      <= 1'b0;
      sent_q    <= 1'b0;
      kind_q    <= MK_LOAD;
      seq_q     <= '0;
      tid_q     <= '0;
      dep_idx_q <= '0;
    end else if (!valid_q) begin
      if (alloc_i) begin
        valid_q   <= 1'b1;
        dying_q   <= 1'b0;
        nonspec_q <= a_nonspec_i;
        regs_q    <= a_regs_i;
        mem_q     <= !a_dep_v_i;
        dep_v_q   <= a_dep_v_i;
        go_q      <= 1'b0;
        sent_q    <= 1'b0;
        kind_q    <= a_kind_i;
        seq_q     <= a_seq_i;
        tid_q     <= a_tid_i;
        dep_idx_q <= a_dep_idx_i;
      end
    end else if (kill || dying_q) begin
      valid_q <= 1'b0;
      dying_q <= 1'b0;
    end else begin
      if (done_hit_o) dying_q <= 1'b1;
      if (regrdy_v_i && regrdy_seq_i == seq_q) regs_q <= 1'b1;
      if (go_v_i && go_seq_i == seq_q) go_q <= 1'b1;
      if (sent_i) sent_q <= 1'b1;
      if (wake_v_i && dep_v_q && dep_idx_q == wake_idx_i) begin
        mem_q   <= 1'b1;
        dep_v_q <= 1'b0;
      end
    end
  end

  assign valid_o    = valid_q;
  assign live_o     = live;
  assign seq_o      = seq_q;
  assign tid_o      = tid_q;
  assign prod_o     = (kind_q != MK_LOAD);
  assign done_hit_o = live && done_v_i && (done_seq_i == seq_q);
  assign cand_o     = live && !sent_q && ((nonspec_q || is_bar) ? go_q : (regs_q && mem_q));
endmodule

// File: rtl/mdu_pick.sv
module mdu_pick #(
  parameter int N     = 16,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]            cand_i,
  input  logic [N-1:0][SEQ_W-1:0] seq_i,
  output logic                    win_v_o,
  output logic [IDX_W-1:0]        win_idx_o
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    win_v_o   = 1'b0;
    win_idx_o = '0;
    best      = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!win_v_o || seq_i[i] < best)) begin
        win_v_o   = 1'b1;
        win_idx_o = IDX_W'(i);
        best      = seq_i[i];
      end
    end
  end
endmodule

// File: rtl/mdu_scoreboard.sv
module mdu_scoreboard
  import mdu_pkg::*;
#(
  parameter int N     = 16,
  parameter int SEQ_W = 16,
  parameter int TID_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_valid_i,
  input  logic [1:0]       ins_kind_i,
  input  logic             ins_nonspec_i,
  input  logic [SEQ_W-1:0] ins_seq_i,
  input  logic [TID_W-1:0] ins_tid_i,
  input  logic [SEQ_W-1:0] ins_pred_i,
  input  logic             ins_regs_rdy_i,
  output logic             full_o,
  input  logic             regrdy_valid_i,
  input  logic [SEQ_W-1:0] regrdy_seq_i,
  input  logic             go_valid_i,
  input  logic [SEQ_W-1:0] go_seq_i,
  input  logic             done_valid_i,
  input  logic [SEQ_W-1:0] done_seq_i,
  input  logic             squash_valid_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic [TID_W-1:0] squash_tid_i,
  output logic             rdy_valid_o,
  output logic [SEQ_W-1:0] rdy_seq_o,
  output logic [TID_W-1:0] rdy_tid_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  mem_kind_e                kind;
  logic [N-1:0]             valid_w, live_w, prod_w, done_hit_w, cand_w, alloc_w, match_w;
  logic [N-1:0][SEQ_W-1:0]  seq_w;
  logic [N-1:0][TID_W-1:0]  tid_w;
  logic                     ld_bar_v_q, st_bar_v_q;
  logic [SEQ_W-1:0]         ld_bar_seq_q, st_bar_seq_q, prod_seq;
  logic                     ins_acc, dep_v, wake_v, win_v;
  logic [IDX_W-1:0]         free_idx, dep_idx, wake_idx, win_idx_w;

  assign kind    = mem_kind_e'(ins_kind_i);
  assign full_o  = &valid_w;
  assign ins_acc = ins_valid_i && !full_o;

  // barrier gate replaces the prediction for the kinds it holds
  always_comb begin
    if (kind == MK_LOAD && ld_bar_v_q)       prod_seq = ld_bar_seq_q;
    else if (kind == MK_STORE && st_bar_v_q) prod_seq = st_bar_seq_q;
    else                                     prod_seq = ins_pred_i;
  end

  always_comb begin
    free_idx = '0;
    dep_idx  = '0;
    wake_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      match_w[i] = live_w[i] && prod_w[i] && !done_hit_w[i] &&
                   (prod_seq != '0) && (seq_w[i] == prod_seq);
      if (!valid_w[i]) free_idx = IDX_W'(i);
      if (match_w[i]) dep_idx = IDX_W'(i);
      if (done_hit_w[i] && prod_w[i]) wake_idx = IDX_W'(i);
    end
  end

  assign dep_v  = (|match_w) && !ins_nonspec_i && (kind == MK_LOAD || kind == MK_STORE);
  assign wake_v = |(done_hit_w & prod_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_bar_v_q   <= 1'b0;
      st_bar_v_q   <= 1'b0;
      ld_bar_seq_q <= '0;
      st_bar_seq_q <= '0;
    end else begin
      if (done_valid_i && ld_bar_v_q && done_seq_i == ld_bar_seq_q) ld_bar_v_q <= 1'b0;
      if (done_valid_i && st_bar_v_q && done_seq_i == st_bar_seq_q) st_bar_v_q <= 1'b0;
      if (ins_acc && kind == MK_FULLBAR) begin
        ld_bar_v_q   <= 1'b1;
        ld_bar_seq_q <= ins_seq_i;
      end
      if (ins_acc && (kind == MK_FULLBAR || kind == MK_WRBAR)) begin
        st_bar_v_q   <= 1'b1;
        st_bar_seq_q <= ins_seq_i;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign alloc_w[g] = ins_acc && (free_idx == IDX_W'(g));
    mdu_entry #(.SEQ_W(SEQ_W), .TID_W(TID_W), .IDX_W(IDX_W)) u_ent (
      .clk_i, .rst_ni,
      .alloc_i     (alloc_w[g]),
      .a_kind_i    (kind),
      .a_nonspec_i (ins_nonspec_i),
      .a_seq_i     (ins_seq_i),
      .a_tid_i     (ins_tid_i),
      .a_regs_i    (ins_regs_rdy_i),
      .a_dep_v_i   (dep_v),
      .a_dep_idx_i (dep_idx),
      .regrdy_v_i  (regrdy_valid_i),
      .regrdy_seq_i(regrdy_seq_i),
      .go_v_i      (go_valid_i),
      .go_seq_i    (go_seq_i),
      .done_v_i    (done_valid_i),
      .done_seq_i  (done_seq_i),
      .sq_v_i      (squash_valid_i),
      .sq_seq_i    (squash_seq_i),
      .sq_tid_i    (squash_tid_i),
      .wake_v_i    (wake_v),
      .wake_idx_i  (wake_idx),
      .sent_i      (win_v && win_idx_w == IDX_W'(g)),
      .valid_o     (valid_w[g]),
      .live_o      (live_w[g]),
      .seq_o       (seq_w[g]),
      .tid_o       (tid_w[g]),
      .prod_o      (prod_w[g]),
      .done_hit_o  (done_hit_w[g]),
      .cand_o      (cand_w[g])
    );
  end

  mdu_pick #(.N(N), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
    .cand_i   (cand_w),
    .seq_i    (seq_w),
    .win_v_o  (win_v),
    .win_idx_o(win_idx_w)
  );

  assign rdy_valid_o = win_v;
  assign rdy_seq_o   = seq_w[win_idx_w];
  assign rdy_tid_o   = tid_w[win_idx_w];
endmodule

// File: rtl/mdu_scoreboard_chk.sv
module mdu_scoreboard_chk
  import mdu_pkg::*;
#(
  parameter int N     = 16,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ins_valid_i,
  input logic [1:0]              ins_kind_i,
  input logic                    full_o,
  input logic                    done_valid_i,
  input logic [SEQ_W-1:0]        done_seq_i,
  input logic                    squash_valid_i,
  input logic                    rdy_valid_o,
  input logic [SEQ_W-1:0]        rdy_seq_o,
  input logic [N-1:0]            cand_w,
  input logic [N-1:0][SEQ_W-1:0] seq_w,
  input logic [IDX_W-1:0]        win_idx_w,
  input logic                    ld_bar_v_q,
  input logic                    st_bar_v_q,
  input logic [SEQ_W-1:0]        st_bar_seq_q
);
  a_r8_winner_is_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_valid_o |-> cand_w[win_idx_w]);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_valid_o |=> !(rdy_valid_o && rdy_seq_o == $past(rdy_seq_o)));

  a_r4_ld_gate_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_bar_v_q) |-> $past(ins_valid_i && !full_o && ins_kind_i == MK_FULLBAR));

  a_r5_st_gate_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_bar_v_q) |-> $past(done_valid_i && done_seq_i == st_bar_seq_q));

  a_r9_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !done_valid_i && !squash_valid_i && !$past(done_valid_i)) |=> full_o);

  always @(posedge clk_i) begin
    if (rst_ni && rdy_valid_o) begin
      for (int i = 0; i < N; i++) begin
        a_r8_oldest: assert (!(cand_w[i] && seq_w[i] < rdy_seq_o));
      end
    end
  end
endmodule

bind mdu_scoreboard mdu_scoreboard_chk #(.N(N), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .ins_valid_i, .ins_kind_i, .full_o, .done_valid_i, .done_seq_i,
  .squash_valid_i, .rdy_valid_o, .rdy_seq_o, .cand_w, .seq_w, .win_idx_w,
  .ld_bar_v_q, .st_bar_v_q, .st_bar_seq_q
);

// File: tb/tb_mdu_scoreboard.sv
`timescale 1ns/1ps
module tb_mdu_scoreboard;
  localparam int SEQ_W = 16;
  localparam int TID_W = 1;
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_FB = 2'd2, K_WB = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_nonspec = 0, ins_regs = 0;
  logic [1:0] ins_kind = 0;
  logic [SEQ_W-1:0] ins_seq = 0, ins_pred = 0, regrdy_seq = 0, go_seq = 0, done_seq = 0, sq_seq = 0;
  logic [TID_W-1:0] ins_tid = 0, sq_tid = 0;
  logic regrdy_valid = 0, go_valid = 0, done_valid = 0, sq_valid = 0;
  logic full, rdy_valid;
  logic [SEQ_W-1:0] rdy_seq;
  logic [TID_W-1:0] rdy_tid;

  always #4 clk = ~clk;

  mdu_scoreboard dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_kind_i(ins_kind), .ins_nonspec_i(ins_nonspec),
    .ins_seq_i(ins_seq), .ins_tid_i(ins_tid), .ins_pred_i(ins_pred), .ins_regs_rdy_i(ins_regs),
    .full_o(full),
    .regrdy_valid_i(regrdy_valid), .regrdy_seq_i(regrdy_seq),
    .go_valid_i(go_valid), .go_seq_i(go_seq),
    .done_valid_i(done_valid), .done_seq_i(done_seq),
    .squash_valid_i(sq_valid), .squash_seq_i(sq_seq), .squash_tid_i(sq_tid),
    .rdy_valid_o(rdy_valid), .rdy_seq_o(rdy_seq), .rdy_tid_o(rdy_tid)
  );

  typedef struct { int seq; int tid; int cyc; string req; } exp_t;
  exp_t q[$];
  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the scoreboard on each pulse
  always @(negedge clk) begin
    if (rst_n && rdy_valid) begin
      n_tests++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected pulse: actual seq=%0d tid=%0d cyc=%0d, expected none", rdy_seq, rdy_tid, cyc);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (int'(rdy_seq) != e.seq || int'(rdy_tid) != e.tid || cyc != e.cyc) begin
          n_fail++;
          $display("FAIL %s pulse: actual seq=%0d tid=%0d cyc=%0d, expected seq=%0d tid=%0d cyc=%0d",
                   e.req, rdy_seq, rdy_tid, cyc, e.seq, e.tid, e.cyc);
        end
      end
    end
  end

  task automatic expect_rdy(input int seq, input int tid, input int dly, input string req);
    exp_t e;
    e.seq = seq; e.tid = tid; e.cyc = cyc + dly; e.req = req;
    q.push_back(e);
  endtask

  task automatic check_full(input logic exp, input string req);
    n_tests++;
    if (full !== exp) begin
      n_fail++;
      $display("FAIL %s full_o: actual %b expected %b", req, full, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ins(input logic [1:0] k, input int seq, input int tid, input int pred,
                        input logic regs, input logic ns);
    ins_valid = 1; ins_kind = k; ins_seq = SEQ_W'(seq); ins_tid = TID_W'(tid);
    ins_pred = SEQ_W'(pred); ins_regs = regs; ins_nonspec = ns;
    @(negedge clk);
    ins_valid = 0; ins_nonspec = 0; ins_regs = 0;
  endtask

  task automatic do_regrdy(input int seq);
    regrdy_valid = 1; regrdy_seq = SEQ_W'(seq);
    @(negedge clk);
    regrdy_valid = 0;
  endtask

  task automatic do_go(input int seq);
    go_valid = 1; go_seq = SEQ_W'(seq);
    @(negedge clk);
    go_valid = 0;
  endtask

  task automatic do_done(input int seq);
    done_valid = 1; done_seq = SEQ_W'(seq);
    @(negedge clk);
    done_valid = 0;
  endtask

  task automatic do_sq(input int seq, input int tid);
    sq_valid = 1; sq_seq = SEQ_W'(seq); sq_tid = TID_W'(tid);
    @(negedge clk);
    sq_valid = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_tests++; n_fail++;
        $display("FAIL %s missing pulse: actual none, expected seq=%0d cyc=%0d", e.req, e.seq, e.cyc);
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    n_tests++;
    if (rdy_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset rdy_valid_o: actual %b expected 0", rdy_valid);
    end
    check_full(1'b0, "R9");

    // R1 no producer / unknown producer
    expect_rdy(10, 0, 1, "R1"); do_ins(K_LD, 10, 0, 0, 1, 0);
    expect_rdy(11, 0, 1, "R1"); do_ins(K_LD, 11, 0, 999, 1, 0);
    do_done(10); do_done(11);

    // R2 register-ready path
    do_ins(K_LD, 12, 0, 0, 0, 0); idle(3);
    expect_rdy(12, 0, 1, "R2"); do_regrdy(12);
    do_done(12);

    // R3 store chain, regs ready vs not
    expect_rdy(20, 0, 1, "R3"); do_ins(K_ST, 20, 0, 0, 1, 0);
    do_ins(K_LD, 21, 0, 20, 1, 0); idle(2);
    expect_rdy(21, 0, 1, "R3"); do_done(20);
    expect_rdy(22, 0, 1, "R3"); do_ins(K_ST, 22, 0, 0, 1, 0);
    do_ins(K_LD, 23, 0, 22, 0, 0);
    do_done(22); idle(2);
    expect_rdy(23, 0, 1, "R3"); do_regrdy(23);
    do_done(21); do_done(23);

    // R10 load named as producer
    expect_rdy(30, 0, 1, "R10"); do_ins(K_LD, 30, 0, 0, 1, 0);
    expect_rdy(31, 0, 1, "R10"); do_ins(K_LD, 31, 0, 30, 1, 0);
    do_done(30); do_done(31);

    // R4 full barrier gates loads and stores
    do_ins(K_FB, 40, 0, 0, 1, 0);
    do_ins(K_LD, 41, 0, 0, 1, 0);
    do_ins(K_ST, 42, 0, 0, 1, 0); idle(2);
    expect_rdy(40, 0, 1, "R6"); do_go(40);
    expect_rdy(41, 0, 1, "R4"); expect_rdy(42, 0, 2, "R8"); do_done(40);
    idle(2);
    // R4 write barrier gates stores only
    do_ins(K_WB, 50, 0, 0, 1, 0);
    expect_rdy(51, 0, 1, "R4"); do_ins(K_LD, 51, 0, 0, 1, 0);
    do_ins(K_ST, 52, 0, 0, 1, 0); idle(2);
    expect_rdy(50, 0, 1, "R6"); do_go(50);
    expect_rdy(52, 0, 1, "R4"); do_done(50);
    do_done(41); do_done(42); do_done(51); do_done(52);

    // R5 younger barrier keeps the gate
    do_ins(K_WB, 60, 0, 0, 1, 0);
    do_ins(K_WB, 61, 0, 0, 1, 0);
    expect_rdy(60, 0, 1, "R6"); do_go(60);
    expect_rdy(61, 0, 1, "R6"); do_go(61);
    do_done(60);
    do_ins(K_ST, 62, 0, 0, 1, 0); idle(3);
    expect_rdy(62, 0, 1, "R5"); do_done(61);
    do_done(62);

    // R6 non-speculative entry waits for go
    do_ins(K_LD, 70, 0, 0, 1, 1); idle(3);
    expect_rdy(70, 0, 1, "R6"); do_go(70);
    do_done(70);

    // R7 squash of thread 1 only
    do_ins(K_ST, 80, 1, 0, 0, 0);
    do_ins(K_LD, 81, 1, 0, 0, 0);
    do_ins(K_LD, 82, 0, 0, 0, 0);
    do_sq(80, 1);
    do_regrdy(81); idle(2);
    expect_rdy(80, 1, 1, "R7"); do_regrdy(80);
    expect_rdy(82, 0, 1, "R7"); do_regrdy(82);
    do_done(80); do_done(82);

    // R8 oldest first when released together
    expect_rdy(94, 0, 1, "R8"); do_ins(K_ST, 94, 0, 0, 1, 0);
    do_ins(K_LD, 96, 0, 94, 1, 0);
    do_ins(K_LD, 95, 0, 94, 1, 0);
    expect_rdy(95, 0, 1, "R8"); expect_rdy(96, 0, 2, "R8"); do_done(94);
    idle(1);
    do_done(95); do_done(96); idle(3);

    // R9 full table, refused insert, delayed free
    for (int s = 100; s < 116; s++) do_ins(K_LD, s, 0, 0, 0, 0);
    check_full(1'b1, "R9");
    do_ins(K_LD, 116, 0, 0, 1, 0); idle(2);
    check_full(1'b1, "R9");
    do_done(100);
    check_full(1'b1, "R9");
    @(negedge clk);
    check_full(1'b0, "R9");
    expect_rdy(116, 0, 1, "R9"); do_ins(K_LD, 116, 0, 0, 1, 0);
    check_full(1'b1, "R9");
    idle(4);
    finish_run();
  end
endmodule